// File: doc/BRIEF.md
# Snooping Test-and-Test-and-Set Lock Requester

Each processor on a shared bus gets one of these engines to acquire and release a single lock word. The engine keeps a one-entry local copy of the lock and polls that copy while it shows the lock taken. While it polls a taken lock it issues no bus transactions. It requests an atomic test-and-set on the bus only after the local copy shows the lock free. A taken lock is any non-zero value. A free lock is zero, and zero is also the value the lock word holds after reset.

The engine snoops every completed bus transaction. When another agent's read returns the lock value, the engine loads that value into its own copy and drops any read it still has pending. If another agent's test-and-set takes the lock while this engine waits for a grant, the engine withdraws its request and goes back to polling. The local copy is invalidated only by a snooped write that actually changes the lock value. The core raises a one-cycle acquire request and sees `acquired` while it owns the lock. It raises a one-cycle release request to give the lock back, and `done` pulses once the clearing write has been seen on the bus.

Bus operation codes on `bus_op` and `snp_kind`:
- 0: read fill.
- 1: test-and-set. It writes a non-zero value and returns the old one.
- 2: write zero.

A snoop carries the source agent, the lock value before the transaction and the lock value after it. The bus grants at most one agent per transaction. A transaction's snoop appears in the cycle after its grant, and no grant is given in a snoop cycle.

Top module: `tts_lock_requester`

## Requirements
- R1: In the cycle after reset, `bus_req`, `acquired` and `done` are all low.
- R2: While the engine is waiting for the lock and its local copy is valid and non-zero, it keeps `bus_req` low.
- R3: After an acquire request with no valid copy, the first bus operation requested is a read fill (op 0). A test-and-set (op 1) is requested only after the local copy has been valid and zero.
- R4: A release request causes a write-zero (op 2) request in the next cycle, and `acquired` drops in that same cycle. After the write, the lock word is zero.
- R5: A snooped read fill from any agent loads the local copy. If the engine has its own read fill pending and ungranted when another agent's fill is snooped, it drops `bus_req` in the next cycle.
- R6: While the engine waits for a grant on a test-and-set, a snooped test-and-set from another agent whose old value is zero makes the engine drop `bus_req` and return to polling. It then requests a read fill (op 0).
- R7: A snooped test-and-set or write from another agent that leaves the value unchanged keeps the local copy valid, so no bus request follows. One that changes the value invalidates the copy, and a read fill request follows.
- R8: If the engine's own test-and-set returns a non-zero old value, `acquired` stays low and the engine goes back to silent polling.
- R9: `acquired` rises in the cycle after the engine's own test-and-set snoop reports an old value of zero. It stays high until release, and acquire requests are ignored meanwhile.
- R10: `done` is high for exactly one cycle, the cycle after the engine's own write-zero snoop. It stays low until that snoop.
- R11: On a shared bus, no two engines hold `acquired` in the same cycle, and every engine that requests the lock acquires it exactly once.
- R12: `bus_req` stays high until a grant arrives. It is low in the cycle after the grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acq_req | input | 1 | Core asks to acquire the lock |
| rel_req | input | 1 | Core asks to release the held lock |
| bus_req | output | 1 | Request for a bus transaction |
| bus_op | output | 2 | Operation of the request: 0 read fill, 1 test-and-set, 2 write zero |
| bus_gnt | input | 1 | Grant; the transaction executes in this cycle |
| snp_valid | input | 1 | A completed transaction is visible on the snoop channel |
| snp_kind | input | 2 | Operation code of the snooped transaction |
| snp_src | input | ID_W | Agent that issued the snooped transaction |
| snp_old | input | LOCK_W | Lock value before the transaction |
| snp_new | input | LOCK_W | Lock value after the transaction |
| acquired | output | 1 | The lock is held by this engine |
| done | output | 1 | One-cycle pulse when a release has completed |

## Verification
The bench uses the default parameters: LOCK_W 8 and ID_W 2. It builds two things.

The first is one engine on whose bus the bench plays every part. The bench places snoops and grants in exact cycles, and it forces snoop values that the shared bus would rarely produce. This brings the rare windows within reach: an abort while waiting for a grant, a failed test-and-set, and a snooped write that leaves the value unchanged.

The second is three engines with agent ids 0 to 2 on a modelled round-robin bus. The bench sweeps every non-empty subset of requesting engines against every start stagger and hold time. This exercises exclusive ownership and exactly-once acquisition under real races.

// File: rtl/tts_pkg.sv
package tts_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_SPIN    = 3'd1,
    ST_REQ_BUS = 3'd2,
    ST_TAS     = 3'd3,
    ST_HELD    = 3'd4,
    ST_RELEASE = 3'd5
  } req_state_e;

  localparam logic [1:0] OP_FILL = 2'd0;
  localparam logic [1:0] OP_TAS  = 2'd1;
  localparam logic [1:0] OP_WR   = 2'd2;
  localparam logic [1:0] OP_NONE = 2'd3;

endpackage

// File: rtl/tts_lock_copy.sv
// One-entry local copy of the lock word, maintained purely from snoops.
module tts_lock_copy
  import tts_pkg::*;
#(
  parameter int LOCK_W   = 8,
  parameter int ID_W     = 2,
  parameter int AGENT_ID = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              snp_valid,
  input  logic [1:0]        snp_kind,
  input  logic [ID_W-1:0]   snp_src,
  input  logic [LOCK_W-1:0] snp_old,
  input  logic [LOCK_W-1:0] snp_new,
  output logic              line_valid,
  output logic              line_busy
);
  localparam logic [ID_W-1:0] SELF = ID_W'(AGENT_ID);

  logic [LOCK_W-1:0] word_q;
  logic              valid_q;
  logic              from_self;
  logic              value_moved;

  assign from_self   = (snp_src == SELF);
  assign value_moved = (snp_old != snp_new);

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      word_q  <= '0;
    end else if (snp_valid) begin
      case (snp_kind)
        OP_FILL: begin
          valid_q <= 1'b1;
          word_q  <= snp_new;
        end
        OP_TAS, OP_WR: begin
          if (from_self) begin
            valid_q <= 1'b1;
            word_q  <= snp_new;
          end else if (value_moved) begin
            valid_q <= 1'b0;
          end
        end
        default: ;
      endcase
    end
  end

  assign line_valid = valid_q;
  assign line_busy  = |word_q;

endmodule

// File: rtl/tts_bus_port.sv
// Registered request toward the bus; tracks a granted transaction until its snoop returns.
module tts_bus_port
  import tts_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       issue,
  input  logic [1:0] issue_op,
  input  logic       withdraw,
  input  logic       bus_gnt,
  input  logic       own_snoop,
  output logic       bus_req,
  output logic [1:0] bus_op,
  output logic       inflight
);
  logic       req_q;
  logic [1:0] op_q;
  logic       fly_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q <= 1'b0;
      op_q  <= OP_NONE;
      fly_q <= 1'b0;
    end else begin
      if (req_q && bus_gnt) begin
        req_q <= 1'b0;
        fly_q <= 1'b1;
      end else if (withdraw) begin
        req_q <= 1'b0;
      end else if (issue) begin
        req_q <= 1'b1;
        op_q  <= issue_op;
      end
      if (own_snoop) fly_q <= 1'b0;
    end
  end

  assign bus_req  = req_q;
  assign bus_op   = op_q;
  assign inflight = fly_q;

endmodule

// File: rtl/tts_req_fsm.sv
// Acquisition sequencer: poll locally, fill on miss, test-and-set when free, abort on rival win.
module tts_req_fsm
  import tts_pkg::*;
#(
  parameter int LOCK_W   = 8,
  parameter int ID_W     = 2,
  parameter int AGENT_ID = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acq_req,
  input  logic              rel_req,
  input  logic              line_valid,
  input  logic              line_busy,
  input  logic              snp_valid,
  input  logic [1:0]        snp_kind,
  input  logic [ID_W-1:0]   snp_src,
  input  logic [LOCK_W-1:0] snp_old,
  input  logic              bus_req,
  input  logic              bus_inflight,
  input  logic              bus_gnt,
  output logic              issue,
  output logic [1:0]        issue_op,
  output logic              withdraw,
  output logic              acquired,
  output logic              done,
  output logic [2:0]        state_o
);
  localparam logic [ID_W-1:0] SELF = ID_W'(AGENT_ID);

  req_state_e st_q, st_d;
  logic       done_q, done_d;
  logic       rival_fill, rival_win, own_tas, own_wr, old_clear;

  assign old_clear  = (snp_old == '0);
  assign rival_fill = snp_valid && (snp_src != SELF) && (snp_kind == OP_FILL);
  assign rival_win  = snp_valid && (snp_src != SELF) && (snp_kind == OP_TAS) && old_clear;
  assign own_tas    = snp_valid && (snp_src == SELF) && (snp_kind == OP_TAS);
  assign own_wr     = snp_valid && (snp_src == SELF) && (snp_kind == OP_WR);

  always_comb begin
    st_d     = st_q;
    issue    = 1'b0;
    issue_op = OP_NONE;
    withdraw = 1'b0;
    done_d   = 1'b0;
    case (st_q)
      ST_IDLE: if (acq_req) st_d = ST_SPIN;
      ST_SPIN: begin
        if (bus_req) begin
          if (rival_fill && !bus_gnt) withdraw = 1'b1;
        end else if (!bus_inflight && !snp_valid) begin
          if (!line_valid) begin
            issue    = 1'b1;
            issue_op = OP_FILL;
          end else if (!line_busy) begin
            issue    = 1'b1;
            issue_op = OP_TAS;
            st_d     = ST_REQ_BUS;
          end
        end
      end
      ST_REQ_BUS: begin
        if (bus_gnt) begin
          st_d = ST_TAS;
        end else if (rival_win) begin
          withdraw = 1'b1;
          st_d     = ST_SPIN;
        end
      end
      ST_TAS: if (own_tas) st_d = old_clear ? ST_HELD : ST_SPIN;
      ST_HELD: begin
        if (rel_req) begin
          issue    = 1'b1;
          issue_op = OP_WR;
          st_d     = ST_RELEASE;
        end
      end
      ST_RELEASE: begin
        if (own_wr) begin
          done_d = 1'b1;
          st_d   = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= done_d;
    end
  end

  assign acquired = (st_q == ST_HELD);
  assign done     = done_q;
  assign state_o  = st_q;

endmodule

// File: rtl/tts_lock_requester.sv
module tts_lock_requester
  import tts_pkg::*;
#(
  parameter int LOCK_W   = 8,
  parameter int ID_W     = 2,
  parameter int AGENT_ID = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acq_req,
  input  logic              rel_req,
  output logic              bus_req,
  output logic [1:0]        bus_op,
  input  logic              bus_gnt,
  input  logic              snp_valid,
  input  logic [1:0]        snp_kind,
  input  logic [ID_W-1:0]   snp_src,
  input  logic [LOCK_W-1:0] snp_old,
  input  logic [LOCK_W-1:0] snp_new,
  output logic              acquired,
  output logic              done
);
  localparam logic [ID_W-1:0] SELF = ID_W'(AGENT_ID);

  logic       line_valid, line_busy;
  logic       issue, withdraw, inflight, own_snoop;
  logic [1:0] issue_op;
  logic [2:0] fsm_state;

  assign own_snoop = snp_valid && (snp_src == SELF);

  tts_lock_copy #(.LOCK_W(LOCK_W), .ID_W(ID_W), .AGENT_ID(AGENT_ID)) u_copy (
    .clk(clk), .rst(rst),
    .snp_valid(snp_valid), .snp_kind(snp_kind), .snp_src(snp_src),
    .snp_old(snp_old), .snp_new(snp_new),
    .line_valid(line_valid), .line_busy(line_busy)
  );

  tts_bus_port u_port (
    .clk(clk), .rst(rst),
    .issue(issue), .issue_op(issue_op), .withdraw(withdraw),
    .bus_gnt(bus_gnt), .own_snoop(own_snoop),
    .bus_req(bus_req), .bus_op(bus_op), .inflight(inflight)
  );

  tts_req_fsm #(.LOCK_W(LOCK_W), .ID_W(ID_W), .AGENT_ID(AGENT_ID)) u_fsm (
    .clk(clk), .rst(rst),
    .acq_req(acq_req), .rel_req(rel_req),
    .line_valid(line_valid), .line_busy(line_busy),
    .snp_valid(snp_valid), .snp_kind(snp_kind), .snp_src(snp_src), .snp_old(snp_old),
    .bus_req(bus_req), .bus_inflight(inflight), .bus_gnt(bus_gnt),
    .issue(issue), .issue_op(issue_op), .withdraw(withdraw),
    .acquired(acquired), .done(done), .state_o(fsm_state)
  );

endmodule

// File: rtl/tts_requester_checker.sv
module tts_requester_checker #(
  parameter int LOCK_W   = 8,
  parameter int ID_W     = 2,
  parameter int AGENT_ID = 0
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_req,
  input logic [1:0]        bus_op,
  input logic              bus_gnt,
  input logic              snp_valid,
  input logic [1:0]        snp_kind,
  input logic [ID_W-1:0]   snp_src,
  input logic [LOCK_W-1:0] snp_old,
  input logic [LOCK_W-1:0] snp_new,
  input logic              acquired,
  input logic              done,
  input logic [2:0]        state,
  input logic              line_valid,
  input logic              line_busy
);
  localparam logic [ID_W-1:0] SELF = ID_W'(AGENT_ID);
  localparam logic [2:0] S_IDLE = 3'd0, S_SPIN = 3'd1, S_REQ = 3'd2, S_TAS = 3'd3, S_HELD = 3'd4;

  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!bus_req && !acquired && !done));

  a_r2_silent_spin: assert property (@(posedge clk) disable iff (rst)
    (state == S_SPIN && line_valid && line_busy && !bus_req && !snp_valid) |=> !bus_req);

  a_r3_tas_after_clear: assert property (@(posedge clk) disable iff (rst)
    ($rose(bus_req) && bus_op == 2'd1) |-> $past(line_valid && !line_busy));

  a_r4_release_from_held: assert property (@(posedge clk) disable iff (rst)
    ($rose(bus_req) && bus_op == 2'd2) |-> $past(state == S_HELD));

  a_r5_fill_loads_copy: assert property (@(posedge clk) disable iff (rst)
    (snp_valid && snp_kind == 2'd0) |=> (line_valid && (line_busy == $past(snp_new != '0))));

  a_r6_abort_on_rival: assert property (@(posedge clk) disable iff (rst)
    (state == S_REQ && !bus_gnt && snp_valid && snp_kind == 2'd1 && snp_src != SELF && snp_old == '0)
    |=> (!bus_req && state == S_SPIN));

  a_r7_keep_on_same: assert property (@(posedge clk) disable iff (rst)
    (snp_valid && snp_kind != 2'd0 && snp_src != SELF && snp_old == snp_new && line_valid) |=> line_valid);

  a_r7_drop_on_change: assert property (@(posedge clk) disable iff (rst)
    (snp_valid && (snp_kind == 2'd1 || snp_kind == 2'd2) && snp_src != SELF && snp_old != snp_new)
    |=> !line_valid);

  a_r8_fail_back: assert property (@(posedge clk) disable iff (rst)
    (state == S_TAS && snp_valid && snp_kind == 2'd1 && snp_src == SELF && snp_old != '0)
    |=> (state == S_SPIN && !acquired));

  a_r9_win_source: assert property (@(posedge clk) disable iff (rst)
    $rose(acquired) |-> $past(snp_valid && snp_kind == 2'd1 && snp_src == SELF && snp_old == '0));

  a_r10_done_source: assert property (@(posedge clk) disable iff (rst)
    done |-> ($past(snp_valid && snp_kind == 2'd2 && snp_src == SELF) && state == S_IDLE));

  a_r12_drop_on_grant: assert property (@(posedge clk) disable iff (rst)
    (bus_req && bus_gnt) |=> !bus_req);

endmodule

bind tts_lock_requester tts_requester_checker #(
  .LOCK_W(LOCK_W), .ID_W(ID_W), .AGENT_ID(AGENT_ID)
) u_chk (
  .clk(clk), .rst(rst), .bus_req(bus_req), .bus_op(bus_op), .bus_gnt(bus_gnt),
  .snp_valid(snp_valid), .snp_kind(snp_kind), .snp_src(snp_src),
  .snp_old(snp_old), .snp_new(snp_new), .acquired(acquired), .done(done),
  .state(fsm_state), .line_valid(line_valid), .line_busy(line_busy)
);

// File: tb/tts_lock_requester_bench.sv
module tts_lock_requester_bench;
  localparam int LW = 8;
  localparam int IW = 2;
  localparam int NP = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  // Manually driven engine (agent 0)
  logic          m_acq = 0, m_rel = 0, m_gnt = 0, m_sv = 0;
  logic [1:0]    m_sk = 0;
  logic [IW-1:0] m_ss = 0;
  logic [LW-1:0] m_so = 0, m_sn = 0;
  logic          m_req, m_acqd, m_done;
  logic [1:0]    m_op;

  tts_lock_requester #(.LOCK_W(LW), .ID_W(IW), .AGENT_ID(0)) u_tts_lock_requester (
    .clk(clk), .rst(rst), .acq_req(m_acq), .rel_req(m_rel),
    .bus_req(m_req), .bus_op(m_op), .bus_gnt(m_gnt),
    .snp_valid(m_sv), .snp_kind(m_sk), .snp_src(m_ss), .snp_old(m_so), .snp_new(m_sn),
    .acquired(m_acqd), .done(m_done)
  );

  // Three engines on a modelled shared bus
  logic [NP-1:0] p_acq = '0, p_rel = '0;
  logic [NP-1:0] p_req, p_gnt, p_acqd, p_done;
  logic [1:0]    p_op [NP];
  logic          s_valid;
  logic [1:0]    s_kind;
  logic [IW-1:0] s_src;
  logic [LW-1:0] s_old, s_new, mem;
  int            rr;

  for (genvar g = 0; g < NP; g++) begin : g_peer
    tts_lock_requester #(.LOCK_W(LW), .ID_W(IW), .AGENT_ID(g)) u_peer (
      .clk(clk), .rst(rst), .acq_req(p_acq[g]), .rel_req(p_rel[g]),
      .bus_req(p_req[g]), .bus_op(p_op[g]), .bus_gnt(p_gnt[g]),
      .snp_valid(s_valid), .snp_kind(s_kind), .snp_src(s_src), .snp_old(s_old), .snp_new(s_new),
      .acquired(p_acqd[g]), .done(p_done[g])
    );
  end

  always_comb begin
    p_gnt = '0;
    if (!s_valid) begin
      for (int k = 0; k < NP; k++) begin
        int idx;
        idx = (rr + k) % NP;
        if (p_req[idx] && p_gnt == '0) p_gnt[idx] = 1'b1;
      end
    end
  end

  always @(posedge clk) begin
    if (rst) begin
      s_valid <= 1'b0; s_kind <= 2'd3; s_src <= '0; s_old <= '0; s_new <= '0;
      mem <= '0; rr <= 0;
    end else begin
      s_valid <= 1'b0;
      for (int i = 0; i < NP; i++) begin
        if (p_gnt[i]) begin
          s_valid <= 1'b1;
          s_src   <= IW'(i);
          s_kind  <= p_op[i];
          s_old   <= mem;
          rr      <= (i + 1) % NP;
          case (p_op[i])
            2'd1:    begin s_new <= 8'd1; mem <= 8'd1; end
            2'd2:    begin s_new <= 8'd0; mem <= 8'd0; end
            default: s_new <= mem;
          endcase
        end
      end
    end
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog R11 actual %0d expected <150000 cycles", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic snoop(logic [1:0] k, logic [IW-1:0] src, logic [LW-1:0] o, logic [LW-1:0] n);
    m_sv = 1'b1; m_sk = k; m_ss = src; m_so = o; m_sn = n;
    step(1);
    m_sv = 1'b0;
  endtask

  task automatic grant_once();
    m_gnt = 1'b1;
    step(1);
    m_gnt = 1'b0;
  endtask

  task automatic quiet_count(string tag, int n);
    int hits = 0;
    for (int i = 0; i < n; i++) begin
      step(1);
      if (m_req) hits++;
    end
    chk(tag, hits, 0);
  endtask

  task automatic run_case(int mask, int stagger, int hold);
    int wins [NP];
    int hcnt [NP];
    int dones = 0;
    int overlap = 0;
    int want;
    logic [NP-1:0] prev = '0;
    bit fin = 0;
    want = $countones(mask[NP-1:0]);
    for (int i = 0; i < NP; i++) begin wins[i] = 0; hcnt[i] = 0; end
    for (int cyc = 0; cyc < 600 && !fin; cyc++) begin
      if ($countones(p_acqd) > 1) overlap++;
      for (int i = 0; i < NP; i++) begin
        if (p_acqd[i] && !prev[i]) wins[i]++;
        if (p_done[i]) dones++;
        p_acq[i] = mask[i] && (cyc == i * stagger);
        if (p_acqd[i]) begin
          hcnt[i]++;
          p_rel[i] = (hcnt[i] == hold);
        end else begin
          hcnt[i] = 0;
          p_rel[i] = 1'b0;
        end
      end
      prev = p_acqd;
      if (dones == want && cyc > 2 * stagger + 1) fin = 1;
      step(1);
    end
    p_acq = '0; p_rel = '0;
    step(3);
    chk("R11 exclusive ownership", overlap, 0);
    for (int i = 0; i < NP; i++) chk("R11 single acquisition", wins[i], int'(mask[i]));
    chk("R10 release completions", dones, want);
    chk("R4 lock word clear after release", int'(mem), 0);
    chk("R12 bus idle after case", int'(p_req), 0);
  endtask

  initial begin
    step(3);
    rst = 1'b0;
    chk("R1 bus_req after reset", m_req, 0);
    chk("R1 acquired after reset", m_acqd, 0);
    chk("R1 done after reset", m_done, 0);
    step(1);
    chk("R1 peers quiet after reset", int'(p_req | p_acqd | p_done), 0);

    // R3: cold copy leads to a read fill first
    m_acq = 1; step(1); m_acq = 0;
    step(1);
    chk("R3 first request raised", m_req, 1);
    chk("R3 first op is read fill", m_op, 0);
    step(3);
    chk("R12 request held without grant", m_req, 1);
    // R5: rival fill supplies a taken value, own read withdrawn
    snoop(2'd0, 2'd1, 8'd1, 8'd1);
    chk("R5 pending fill withdrawn", m_req, 0);
    quiet_count("R2 silent polling on taken copy", 10);

    // R7: unchanged value keeps copy; changed value invalidates
    snoop(2'd1, 2'd1, 8'd1, 8'd1);
    step(2);
    chk("R7 unchanged snoop keeps copy", m_req, 0);
    snoop(2'd2, 2'd1, 8'd1, 8'd0);
    step(1);
    chk("R7 changed snoop forces refetch", m_req, 1);
    chk("R7 refetch op is read fill", m_op, 0);

    grant_once();
    chk("R12 request drops after grant", m_req, 0);
    snoop(2'd0, 2'd0, 8'd0, 8'd0);
    step(1);
    chk("R3 test-and-set after free copy", m_req, 1);
    chk("R3 op is test-and-set", m_op, 1);

    // R6: rival wins while waiting for grant
    snoop(2'd1, 2'd1, 8'd0, 8'd1);
    chk("R6 request withdrawn on rival win", m_req, 0);
    chk("R6 not acquired", m_acqd, 0);
    step(1);
    chk("R6 back to polling with read fill", m_req, 1);
    chk("R6 refetch op", m_op, 0);

    // R8: own test-and-set fails
    grant_once();
    snoop(2'd0, 2'd0, 8'd0, 8'd0);
    step(1);
    chk("R8 test-and-set requested", m_op, 1);
    grant_once();
    snoop(2'd1, 2'd0, 8'd1, 8'd1);
    chk("R8 acquired stays low on failure", m_acqd, 0);
    quiet_count("R8 silent after failed attempt", 5);

    // R9: successful acquisition
    snoop(2'd2, 2'd1, 8'd1, 8'd0);
    step(1);
    grant_once();
    snoop(2'd0, 2'd0, 8'd0, 8'd0);
    step(1);
    m_acq = 1;
    grant_once();
    chk("R9 not acquired before own snoop", m_acqd, 0);
    snoop(2'd1, 2'd0, 8'd0, 8'd1);
    chk("R9 acquired after own win", m_acqd, 1);
    step(4);
    m_acq = 0;
    chk("R9 acquired held", m_acqd, 1);
    chk("R9 no bus traffic while held", m_req, 0);

    // R4 / R10: release
    m_rel = 1; step(1); m_rel = 0;
    chk("R4 write requested", m_req, 1);
    chk("R4 op is write zero", m_op, 2);
    chk("R4 acquired dropped", m_acqd, 0);
    grant_once();
    chk("R10 no done before own write snoop", m_done, 0);
    snoop(2'd2, 2'd0, 8'd1, 8'd0);
    chk("R10 done pulse", m_done, 1);
    step(1);
    chk("R10 done single cycle", m_done, 0);
    chk("R10 idle after release", m_req, 0);

    // R11: shared-bus sweep
    for (int mask = 1; mask < 8; mask++)
      for (int st = 0; st < 3; st++)
        for (int h = 1; h < 4; h++)
          run_case(mask, st, h);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule